// File: doc/BRIEF.md
# Power Button Long-Press Reset

This block watches a set of active-low power-button pins running on the 32.768 kHz always-on clock. Each pin goes through a synchronizer and a counter debouncer. Every debounced press raises a one-cycle button interrupt for that pin. A press on its own never powers the part down. Software reacts to the interrupt and decides what to do.

Each button has its own long-press enable, and all enables are off after reset. When a button is enabled and held for the long-press time (4 s, which is 128 ticks of the clock divided by 1024), the block issues a single turn-off request. It also sets a sticky system-reset flag. The flag survives the Off state and is reported as an interrupt at the next power-up indication. A clear pulse removes the flag once it has been reported. When the restart enable is set, a restart request accompanies the turn-off request so that the power sequencer brings the part back up.

Top module: `pwr_key_reset`

## Requirements
- R1: Each debounced press of button k gives exactly one one-cycle pulse on `key_irq_o[k]`, whatever the enables are. A press alone never asserts `off_req_o`.
- R2: After a two-flop synchronizer, a pin level must persist for `DEB_CYCLES` consecutive cycles before it is accepted. A low glitch shorter than `DEB_CYCLES` cycles gives no interrupt.
- R3: With `lp_en_i[k]` = 0, holding button k for any length of time never produces `off_req_o` or `restart_req_o`.
- R4: With `lp_en_i[k]` = 1, a debounced hold of at least `HOLD_TICKS*TICK_DIV` cycles produces one `off_req_o` pulse that is exactly one cycle long. A hold shorter than `(HOLD_TICKS-1)*TICK_DIV` cycles produces none.
- R5: Releasing the button clears the accumulated hold count, so two short holds never add up to a long press.
- R6: Only one turn-off request is issued per hold, however long the button stays down. The button must be released before another request can be issued.
- R7: `restart_req_o` pulses in the same cycle as `off_req_o` when `restart_en_i` = 1, and it never pulses otherwise.
- R8: A long-press request arms the system-reset flag while `sysrst_irq_o` stays low. The next `power_up_i` pulse raises `sysrst_irq_o`. A `power_up_i` pulse with no armed flag leaves it low.
- R9: A `sysrst_clr_i` pulse drops a reported `sysrst_irq_o`. A clear that arrives before the power-up report is ignored, and the flag is still reported later.
- R10: After reset, all outputs are low.
- R11: The enables work per button. A long hold on a button whose enable is clear produces no request, even while another button's enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz always-on clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| key_ni | input | NUM_KEYS | Raw active-low button pins |
| lp_en_i | input | NUM_KEYS | Per-button long-press reset enable |
| restart_en_i | input | 1 | Request an automatic restart after a long-press reset |
| power_up_i | input | 1 | One-cycle pulse at each power-up |
| sysrst_clr_i | input | 1 | One-cycle write-one clear of the reported system-reset flag |
| key_irq_o | output | NUM_KEYS | One-cycle press interrupt per button |
| sysrst_irq_o | output | 1 | System-reset interrupt, high from the power-up report until cleared |
| off_req_o | output | 1 | One-cycle turn-off request |
| restart_req_o | output | 1 | One-cycle automatic restart request |

## Verification
The bench runs a small configuration of the block. It first sweeps low glitches of every length below the debounce window, then presses that just clear it, which separates filtered noise from real presses. For each button and each restart setting, holds of several lengths on both sides of the hold window tell apart a missing, a premature, a repeated and an over-long turn-off request, and show whether the restart request goes with it. Split holds, holds on a button whose enable is clear, and clear and power-up pulses given in either order show that the count is cleared on release, that the enables apply per button, and that the flag is reported in the right order.

// File: rtl/pwr_key_pkg.sv
package pwr_key_pkg;
  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_PEND = 2'd1,
    SR_RPT  = 2'd2
  } sr_state_e;
endpackage

// File: rtl/pwr_key_tick.sv
module pwr_key_tick #(
  parameter int TICK_DIV = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(TICK_DIV);
      localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);

      assert_tick_sparse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pwr_key_debounce.sv
module pwr_key_debounce #(
  parameter int DEB_CYCLES = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ni,
  output logic held_o,
  output logic press_o
);
  localparam int W = $clog2(DEB_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(DEB_CYCLES - 1);

  logic [1:0]   sync_q;
  logic         stable_q;
  logic [W-1:0] cnt_q;
  logic         press_q;
  logic         diff;

  assign diff = (sync_q[1] != stable_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 2'b11;
      stable_q <= 1'b1;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], key_ni};
      press_q <= diff && (cnt_q == LAST) && !sync_q[1];
      if (!diff) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign held_o  = ~stable_q;
  assign press_o = press_q;

  // accepted level must have differed from the old one
  assert_deb_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stable_q) |-> $past(sync_q[1]) != $past(stable_q));
  assert_press_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |-> held_o);
  assert_press_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |=> !press_q);
endmodule

// File: rtl/pwr_key_hold.sv
module pwr_key_hold #(
  parameter int HOLD_TICKS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic held_i,
  input  logic en_i,
  output logic fire_o
);
  localparam int W = $clog2(HOLD_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(HOLD_TICKS - 1);

  logic [W-1:0] cnt_q;
  logic         done_q;
  logic         fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (!held_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!en_i) begin
        cnt_q <= '0;
      end else if (tick_i && !done_q) begin
        if (cnt_q == LAST) begin
          fire_q <= 1'b1;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

  assert_fire_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  assert_fire_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(held_i && en_i));
  assert_release_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!held_i) |-> cnt_q == '0 && !done_q);
endmodule

// File: rtl/pwr_key_sysrst.sv
module pwr_key_sysrst
  import pwr_key_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic power_up_i,
  input  logic clr_i,
  output logic irq_o
);
  sr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (set_i) state_d = SR_PEND;
    else begin
      case (state_q)
        SR_PEND: if (power_up_i) state_d = SR_RPT;
        SR_RPT:  if (clr_i) state_d = SR_IDLE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SR_IDLE;
    else state_q <= state_d;
  end

  assign irq_o = (state_q == SR_RPT);

  assert_irq_on_powerup_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(power_up_i));
  assert_clr_needs_report_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_i || set_i));
endmodule

// File: rtl/pwr_key_reset.sv
module pwr_key_reset #(
  parameter int NUM_KEYS   = 2,
  parameter int DEB_CYCLES = 33,
  parameter int TICK_DIV   = 1024,
  parameter int HOLD_TICKS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] key_ni,
  input  logic [NUM_KEYS-1:0] lp_en_i,
  input  logic                restart_en_i,
  input  logic                power_up_i,
  input  logic                sysrst_clr_i,
  output logic [NUM_KEYS-1:0] key_irq_o,
  output logic                sysrst_irq_o,
  output logic                off_req_o,
  output logic                restart_req_o
);
  logic                tick;
  logic [NUM_KEYS-1:0] held;
  logic [NUM_KEYS-1:0] fire;
  logic                off_q, restart_q;

  pwr_key_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    pwr_key_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .key_ni (key_ni[k]),
      .held_o (held[k]),
      .press_o(key_irq_o[k])
    );
    pwr_key_hold #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .held_i(held[k]),
      .en_i  (lp_en_i[k]),
      .fire_o(fire[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      off_q     <= |fire;
      restart_q <= (|fire) && restart_en_i;
    end
  end

  pwr_key_sysrst i_sysrst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (|fire),
    .power_up_i(power_up_i),
    .clr_i     (sysrst_clr_i),
    .irq_o     (sysrst_irq_o)
  );

  assign off_req_o     = off_q;
  assign restart_req_o = restart_q;

  assert_restart_with_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_req_o |-> off_req_o);
  assert_off_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |=> !off_req_o);
  assert_off_needs_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |-> $past(|held));
endmodule

// File: tb/test_pwr_key_reset.sv
module test_pwr_key_reset;
  localparam int NK   = 2;
  localparam int DEB  = 4;
  localparam int DIV  = 8;
  localparam int HOLD = 6;
  localparam int LONG_MIN  = HOLD * DIV;
  localparam int SHORT_MAX = (HOLD - 1) * DIV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NK-1:0] key_n = '1;
  logic [NK-1:0] lp_en = '0;
  logic          restart_en = 1'b0;
  logic          power_up = 1'b0;
  logic          clr = 1'b0;
  logic [NK-1:0] key_irq;
  logic          sysrst_irq, off_req, restart_req;

  int n_chk = 0, n_bad = 0;
  int off_cnt = 0, rst_cnt = 0;
  int press_cnt [NK];
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_key_reset #(.NUM_KEYS(NK), .DEB_CYCLES(DEB), .TICK_DIV(DIV), .HOLD_TICKS(HOLD)) i_pwr_key_reset (
    .clk_i(clk), .rst_ni(rst_n), .key_ni(key_n), .lp_en_i(lp_en),
    .restart_en_i(restart_en), .power_up_i(power_up), .sysrst_clr_i(clr),
    .key_irq_o(key_irq), .sysrst_irq_o(sysrst_irq), .off_req_o(off_req),
    .restart_req_o(restart_req)
  );

  initial for (int i = 0; i < NK; i++) press_cnt[i] = 0;

  always @(negedge clk) if (rst_n) begin
    if (off_req) off_cnt++;
    if (restart_req) rst_cnt++;
    for (int i = 0; i < NK; i++) if (key_irq[i]) press_cnt[i]++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hold_key(input int k, input int len);
    key_n[k] = 1'b0;
    cyc(len);
    key_n[k] = 1'b1;
    cyc(DEB + 8);
  endtask

  initial begin
    int o0, r0, p0;
    cyc(3);
    // R10 reset state
    check("R10 key_irq", int'(key_irq), 0);
    check("R10 off/restart/sysrst", int'({off_req, restart_req, sysrst_irq}), 0);
    rst_n = 1'b1;
    cyc(DIV + 2);

    // R2 glitch sweep, R1 accepted press
    for (int k = 0; k < NK; k++) begin
      for (int g = 1; g < DEB; g++) begin
        p0 = press_cnt[k];
        hold_key(k, g);
        check("R2 glitch filtered", press_cnt[k] - p0, 0);
      end
      p0 = press_cnt[k];
      hold_key(k, DEB + 2);
      check("R1 press irq", press_cnt[k] - p0, 1);
    end

    // R3 disabled long hold, R1 press without power-off
    for (int k = 0; k < NK; k++) begin
      o0 = off_cnt; p0 = press_cnt[k];
      hold_key(k, 3 * LONG_MIN);
      check("R3 no off when disabled", off_cnt - o0, 0);
      check("R1 press irq once", press_cnt[k] - p0, 1);
    end

    // R4/R6/R7/R11 sweep over key and restart setting
    for (int rs = 0; rs < 2; rs++) begin
      restart_en = rs[0];
      for (int k = 0; k < NK; k++) begin
        lp_en = '0;
        lp_en[k] = 1'b1;
        for (int s = 1; s <= 4; s++) begin
          o0 = off_cnt;
          hold_key(k, s * (SHORT_MAX - 2) / 4);
          check("R4 short hold", off_cnt - o0, 0);
        end
        for (int l = 0; l < 3; l++) begin
          o0 = off_cnt; r0 = rst_cnt;
          hold_key(k, LONG_MIN + DEB + 6 + l * 2 * LONG_MIN);
          check(l == 0 ? "R4 long hold" : "R6 single request", off_cnt - o0, 1);
          check("R7 restart follows enable", rst_cnt - r0, rs);
        end
        o0 = off_cnt;
        hold_key(NK - 1 - k, 3 * LONG_MIN);
        check("R11 other key disabled", off_cnt - o0, 0);
      end
    end
    restart_en = 1'b0;

    // R5 split holds
    lp_en = '1;
    o0 = off_cnt;
    hold_key(0, SHORT_MAX - 10);
    hold_key(0, SHORT_MAX - 10);
    check("R5 release clears count", off_cnt - o0, 0);

    // R8/R9 sticky flag (armed by the long holds above)
    check("R8 pending not yet reported", int'(sysrst_irq), 0);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
    check("R9 early clear ignored", int'(sysrst_irq), 0);
    power_up = 1'b1; cyc(1); power_up = 1'b0; cyc(1);
    check("R8 reported on power-up", int'(sysrst_irq), 1);
    cyc(5);
    check("R8 report held", int'(sysrst_irq), 1);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    check("R9 clear after report", int'(sysrst_irq), 0);
    power_up = 1'b1; cyc(1); power_up = 1'b0; cyc(2);
    check("R8 no flag no irq", int'(sysrst_irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule